// File: doc/BRIEF.md
# Expansion Bus Access Sequencer

This block carries out a single CPU access on a byte-wide expansion bus. The bus address is 24 bits: a 4-bit device number forms the top nibble and a 20-bit offset fills the bits below it. An address decoder hands the block a request made of a device number, an offset, a direction flag and a write byte. The block presents the address and then raises a read or write strobe. It holds the strobe for a number of slow bus ticks that software sets for each device. When the access completes it returns the read byte together with a one-cycle completion pulse.

The bus runs on a clock enable derived from the system clock by a programmable divisor, so a remapped device is always reached at bus speed and never at local-memory speed. The block also owns a small configuration register file. That file stores a CPU clock divisor, which is exported for use elsewhere, the bus clock divisor, and one wait-state byte for each of the sixteen devices. After reset both divisors are zero and every wait byte is 0x0F.

Top module: `xbus_seq`

## Requirements
- R1: After reset the CPU divisor and the bus divisor read 0, all sixteen wait bytes read 0x0F, `req_ready` is high, and `bus_rd`, `bus_wr` and `rsp_done` are low.
- R2: Configuration offsets are fixed. 0x00 holds the CPU divisor, which also appears on `cpu_clk_div`. 0x01 holds the bus divisor. 0x10+d holds the wait byte of device d. `cfg_rdata` shows the register selected by `cfg_addr` in the same cycle. Every other offset reads 0 and ignores writes.
- R3: `bus_clk_en` is high in exactly one system cycle of every (bus divisor + 1). With a divisor of 0 it is high in every cycle.
- R4: While a strobe is high, `bus_addr` equals {device[23:20], offset[19:0]} of the request and does not change. `bus_rd` marks reads and `bus_wr` marks writes, and the two are never high together.
- R5: The strobe stays high for exactly W+1 bus clock enable pulses and falls right after the last of them. W is the wait byte of the target device at the moment the request is accepted.
- R6: For a read, `rsp_rdata` holds the value that `bus_din` carried on the last strobed bus tick.
- R7: A request is accepted on a cycle with `req_valid` and `req_ready` both high. `req_ready` then stays low until the access ends. `rsp_done` is high for exactly one cycle, the cycle right after the strobe falls, and `req_ready` returns high in the next cycle.
- R8: For a write, `bus_dout` equals the request's write byte for as long as `bus_wr` is high.
- R9: After acceptance the address phase lasts exactly one bus clock enable pulse, with both strobes low, before the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` |
| cpu_clk_div | output | 8 | Current CPU clock divisor |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_dev | input | 4 | Target device number |
| req_off | input | 20 | Offset within the device |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last read byte |
| bus_clk_en | output | 1 | Bus clock enable pulse |
| bus_addr | output | 24 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_dout | output | 8 | Bus write data |
| bus_din | input | 8 | Bus read data |

## Verification
The bench gives `bus_din` a value that changes on every strobed tick. A design that samples read data on any tick other than the final one therefore returns the wrong byte. Transfers use wait bytes of 0, 15 and 255 and bus divisors up to 255. An off-by-one in the wait countdown, or an address phase that is skipped or runs long, shows up as a wrong count of strobed ticks or address-phase ticks. Writes to unmapped offsets, and to the offset just past the wait table, must read back as zero and must leave the mapped registers unchanged. A decoder that aliased offsets would corrupt a divisor or a wait byte.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   localparam int XB_CPU_DIV_OFF = 0;
   localparam int XB_BUS_DIV_OFF = 1;
   localparam int XB_WS_BASE     = 16;

   typedef enum logic [2:0] {
      XS_IDLE,
      XS_ADDR,
      XS_WAIT,
      XS_DATA,
      XS_DONE
   } xbus_state_e;
endpackage

// File: rtl/xbus_cfg_regs.sv
module xbus_cfg_regs #(
   parameter int          AW      = 8,
   parameter int          DW      = 8,
   parameter int          NDEV    = 16,
   parameter int          CPU_OFF = xbus_pkg::XB_CPU_DIV_OFF,
   parameter int          BUS_OFF = xbus_pkg::XB_BUS_DIV_OFF,
   parameter int          WS_BASE = xbus_pkg::XB_WS_BASE,
   parameter logic [DW-1:0] WS_RST = 8'h0F
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [AW-1:0]      addr,
   input  logic [DW-1:0]      wdata,
   output logic [DW-1:0]      rdata,
   output logic [DW-1:0]      cpu_div,
   output logic [DW-1:0]      bus_div,
   output logic [NDEV*DW-1:0] ws_flat
);
   localparam logic [AW-1:0] CPU_A = AW'(CPU_OFF);
   localparam logic [AW-1:0] BUS_A = AW'(BUS_OFF);

   if (WS_BASE + NDEV > (1 << AW)) begin : g_bad_map
      $error("wait table does not fit in the configuration offset range");
   end
   if (WS_BASE <= CPU_OFF || WS_BASE <= BUS_OFF) begin : g_bad_overlap
      $error("wait table overlaps the divisor registers");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_div <= '0;
         bus_div <= '0;
      end else if (we) begin
         if (addr == CPU_A) cpu_div <= wdata;
         if (addr == BUS_A) bus_div <= wdata;
      end
   end

   for (genvar g = 0; g < NDEV; g++) begin : g_ws
      localparam logic [AW-1:0] SLOT = AW'(WS_BASE + g);
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    q <= WS_RST;
         else if (we && addr == SLOT)   q <= wdata;
      end
      assign ws_flat[g*DW +: DW] = q;
   end

   always_comb begin
      rdata = '0;
      if (addr == CPU_A) rdata = cpu_div;
      if (addr == BUS_A) rdata = bus_div;
      for (int i = 0; i < NDEV; i++) begin
         if (addr == AW'(WS_BASE + i)) rdata = ws_flat[i*DW +: DW];
      end
   end
endmodule

// File: rtl/xbus_tick_gen.sv
module xbus_tick_gen #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] div,
   output logic          tick
);
   logic [DW-1:0] cnt;

   // the >= compare recovers at once when the divisor drops below the count
   assign tick = (cnt >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
   import xbus_pkg::*;
#(
   parameter int DEV_W = 4,
   parameter int OFF_W = 20,
   parameter int DW    = 8,
   localparam int NDEV   = 1 << DEV_W,
   localparam int BUS_AW = DEV_W + OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [NDEV*DW-1:0] ws_flat,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [DEV_W-1:0]   req_dev,
   input  logic [OFF_W-1:0]   req_off,
   input  logic               req_wr,
   input  logic [DW-1:0]      req_wdata,
   output logic               rsp_done,
   output logic [DW-1:0]      rsp_rdata,
   output logic [BUS_AW-1:0]  bus_addr,
   output logic               bus_rd,
   output logic               bus_wr,
   output logic [DW-1:0]      bus_dout,
   input  logic [DW-1:0]      bus_din
);
   xbus_state_e st;
   logic [BUS_AW-1:0] addr_q;
   logic              wr_q;
   logic [DW-1:0]     wd_q;
   logic [DW-1:0]     ws_q;
   logic [DW-1:0]     wcnt;
   logic [DW-1:0]     ws_sel;
   logic              strobe;

   always_comb begin
      ws_sel = '0;
      for (int i = 0; i < NDEV; i++) begin
         if (req_dev == DEV_W'(i)) ws_sel = ws_flat[i*DW +: DW];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= XS_IDLE;
         addr_q    <= '0;
         wr_q      <= 1'b0;
         wd_q      <= '0;
         ws_q      <= '0;
         wcnt      <= '0;
         rsp_rdata <= '0;
      end else begin
         case (st)
            XS_IDLE: if (req_valid) begin
               addr_q <= {req_dev, req_off};
               wr_q   <= req_wr;
               wd_q   <= req_wdata;
               ws_q   <= ws_sel;
               st     <= XS_ADDR;
            end
            XS_ADDR: if (tick) begin
               wcnt <= ws_q;
               st   <= (ws_q == '0) ? XS_DATA : XS_WAIT;
            end
            XS_WAIT: if (tick) begin
               wcnt <= wcnt - 1'b1;
               if (wcnt == DW'(1)) st <= XS_DATA;
            end
            XS_DATA: if (tick) begin
               if (!wr_q) rsp_rdata <= bus_din;
               st <= XS_DONE;
            end
            default: st <= XS_IDLE;
         endcase
      end
   end

   assign strobe    = (st == XS_WAIT) || (st == XS_DATA);
   assign bus_rd    = strobe && !wr_q;
   assign bus_wr    = strobe && wr_q;
   assign bus_addr  = addr_q;
   assign bus_dout  = wd_q;
   assign req_ready = (st == XS_IDLE);
   assign rsp_done  = (st == XS_DONE);
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq #(
   parameter int DEV_W  = 4,
   parameter int OFF_W  = 20,
   parameter int DW     = 8,
   parameter int CFG_AW = 8,
   parameter logic [DW-1:0] WS_RST = 8'h0F,
   localparam int NDEV   = 1 << DEV_W,
   localparam int BUS_AW = DEV_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [DW-1:0]     cfg_wdata,
   output logic [DW-1:0]     cfg_rdata,
   output logic [DW-1:0]     cpu_clk_div,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [OFF_W-1:0]  req_off,
   input  logic              req_wr,
   input  logic [DW-1:0]     req_wdata,
   output logic              rsp_done,
   output logic [DW-1:0]     rsp_rdata,
   output logic              bus_clk_en,
   output logic [BUS_AW-1:0] bus_addr,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic [DW-1:0]     bus_dout,
   input  logic [DW-1:0]     bus_din
);
   if (DEV_W < 1 || OFF_W < 1 || DW < 1) begin : g_bad_width
      $error("device, offset and data widths must be positive");
   end

   logic [DW-1:0]      bus_div;
   logic [NDEV*DW-1:0] ws_flat;

   xbus_cfg_regs #(
      .AW(CFG_AW), .DW(DW), .NDEV(NDEV), .WS_RST(WS_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata), .cpu_div(cpu_clk_div),
      .bus_div(bus_div), .ws_flat(ws_flat)
   );

   xbus_tick_gen #(.DW(DW)) u_tick (
      .clk(clk), .rst_n(rst_n), .div(bus_div), .tick(bus_clk_en)
   );

   xbus_fsm #(.DEV_W(DEV_W), .OFF_W(OFF_W), .DW(DW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .tick(bus_clk_en), .ws_flat(ws_flat),
      .req_valid(req_valid), .req_ready(req_ready), .req_dev(req_dev),
      .req_off(req_off), .req_wr(req_wr), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_dout(bus_dout),
      .bus_din(bus_din)
   );
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
   parameter int ADDR_W = 24,
   parameter int DW     = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_clk_en,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              rsp_done,
   input logic              req_ready,
   input logic [DW-1:0]     bus_div
);
   // R4
   one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

   // R3
   full_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_div == '0) |-> bus_clk_en);

   // R3
   div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_div != '0 && bus_clk_en) |=> (!bus_clk_en || bus_div != $past(bus_div)));

   // R4
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rd || bus_wr) && $past(bus_rd || bus_wr)) |-> $stable(bus_addr));

   // R5
   strobe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_rd || bus_wr) && !(bus_rd || bus_wr)) |-> $past(bus_clk_en));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R7
   done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (!req_ready && !bus_rd && !bus_wr));
endmodule

bind xbus_seq xbus_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_clk_en(bus_clk_en), .bus_rd(bus_rd),
   .bus_wr(bus_wr), .bus_addr(bus_addr), .rsp_done(rsp_done),
   .req_ready(req_ready), .bus_div(bus_div)
);

// File: tb/xbus_seq_tb.sv
`timescale 1ns/1ps
module xbus_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata, cpu_clk_div;
   logic        req_valid = 1'b0, req_ready;
   logic [3:0]  req_dev = '0;
   logic [19:0] req_off = '0;
   logic        req_wr = 1'b0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_done;
   logic [7:0]  rsp_rdata;
   logic        bus_clk_en, bus_rd, bus_wr;
   logic [23:0] bus_addr;
   logic [7:0]  bus_dout, bus_din;
   logic [7:0]  din_mod = '0;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] ws_m [16];
   logic [7:0] cdiv_m, bdiv_m;

   always #2 clk = ~clk;

   xbus_seq u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cpu_clk_div(cpu_clk_div),
      .req_valid(req_valid), .req_ready(req_ready), .req_dev(req_dev),
      .req_off(req_off), .req_wr(req_wr), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_clk_en(bus_clk_en),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_dout(bus_dout), .bus_din(bus_din)
   );

   function automatic logic [7:0] pat(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h5A;
   endfunction

   assign bus_din = pat(bus_addr) ^ din_mod;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a == 8'h00) cdiv_m = d;
      if (a == 8'h01) bdiv_m = d;
      if (a >= 8'h10 && a <= 8'h1F) ws_m[a[3:0]] = d;
   endtask

   task automatic cfg_rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
      @(negedge clk);
      cfg_addr = a;
      #1;
      check(tag, cfg_rdata, exp);
   endtask

   task automatic div_test(input logic [7:0] d);
      int ticks = 0;
      cfg_wr(8'h01, d);
      repeat (300) @(negedge clk);
      for (int i = 0; i < 8 * (int'(d) + 1); i++) begin
         if (bus_clk_en) ticks++;
         @(negedge clk);
      end
      check($sformatf("R3 tick count div=%0d", d), ticks, 8);
   endtask

   task automatic txn(input logic [3:0] dev, input logic [19:0] off,
                      input logic wr, input logic [7:0] wd);
      int addr_ticks = 0, st_ticks = 0, cyc = 0;
      bit seen = 0, addr_bad = 0, dir_bad = 0, dout_bad = 0, rdy_bad = 0, prev_st = 0;
      logic [7:0] w;
      logic [23:0] ea;
      w  = ws_m[dev];
      ea = {dev, off};
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      din_mod = '0;
      req_valid = 1'b1; req_dev = dev; req_off = off; req_wr = wr; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_done && cyc < 20000) begin
         if (req_ready) rdy_bad = 1;
         if (bus_rd || bus_wr) begin
            seen = 1;
            if (bus_addr !== ea) addr_bad = 1;
            if (bus_wr !== wr || bus_rd !== !wr) dir_bad = 1;
            if (wr && bus_dout !== wd) dout_bad = 1;
            if (bus_clk_en) begin
               st_ticks++;
               din_mod = 8'(st_ticks);
            end
         end else if (!seen && bus_clk_en) addr_ticks++;
         prev_st = bus_rd || bus_wr;
         @(negedge clk);
         cyc++;
      end
      check("R7 done reached", rsp_done, 1'b1);
      check("R7 done follows strobe", prev_st, 1'b1);
      check("R7 ready low while busy", rdy_bad, 1'b0);
      check("R9 address phase ticks", addr_ticks, 1);
      check("R5 strobed ticks", st_ticks, int'(w) + 1);
      check("R4 address and direction", {addr_bad, dir_bad}, 2'b00);
      if (wr) check("R8 write data", dout_bad, 1'b0);
      else    check("R6 read data", rsp_rdata, pat(ea) ^ 8'(int'(w) + 1));
      @(negedge clk);
      check("R7 done one cycle", {rsp_done, req_ready}, 2'b01);
   endtask

   initial begin
      #(4 * 190000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 16; i++) ws_m[i] = 8'h0F;
      cdiv_m = '0; bdiv_m = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 ready/strobes/done", {req_ready, bus_rd, bus_wr, rsp_done}, 4'b1000);
      cfg_rd("R1 cpu divisor", 8'h00, 8'h00);
      cfg_rd("R1 bus divisor", 8'h01, 8'h00);
      for (int i = 0; i < 16; i++) cfg_rd("R1 wait byte", 8'(16 + i), 8'h0F);

      // R2 register map, readback and unmapped offsets
      cfg_wr(8'h00, 8'h37);
      cfg_rd("R2 cpu divisor readback", 8'h00, 8'h37);
      check("R2 cpu_clk_div port", cpu_clk_div, 8'h37);
      cfg_wr(8'h13, 8'h02);
      cfg_rd("R2 wait byte dev3", 8'h13, 8'h02);
      cfg_wr(8'h05, 8'hAA);
      cfg_wr(8'h20, 8'h55);
      cfg_wr(8'h0F, 8'h66);
      cfg_rd("R2 unmapped 0x05 reads 0", 8'h05, 8'h00);
      cfg_rd("R2 unmapped 0x20 reads 0", 8'h20, 8'h00);
      cfg_rd("R2 cpu divisor untouched", 8'h00, 8'h37);
      cfg_rd("R2 bus divisor untouched", 8'h01, 8'h00);
      cfg_rd("R2 last wait byte untouched", 8'h1F, 8'h0F);
      cfg_rd("R2 first wait byte untouched", 8'h10, 8'h0F);

      // R3 divisor periods
      div_test(8'd0);
      div_test(8'd1);
      div_test(8'd3);
      div_test(8'd255);
      cfg_wr(8'h01, 8'd0);

      // directed transfers
      txn(4'h7, 20'hABCDE, 1'b0, 8'h00);
      txn(4'h3, 20'h00001, 1'b1, 8'hC3);
      cfg_wr(8'h15, 8'h00);
      txn(4'h5, 20'hFFFFF, 1'b0, 8'h00);
      txn(4'h5, 20'h12345, 1'b1, 8'h81);
      cfg_wr(8'h1F, 8'hFF);
      cfg_wr(8'h01, 8'd1);
      txn(4'hF, 20'h00000, 1'b0, 8'h00);
      cfg_wr(8'h01, 8'd2);
      txn(4'h0, 20'h80000, 1'b1, 8'h7E);

      // constrained random transfers
      for (int n = 0; n < 40; n++) begin
         if ($urandom_range(0, 3) == 0)
            cfg_wr(8'(16 + $urandom_range(0, 15)), 8'($urandom_range(0, 20)));
         if ($urandom_range(0, 6) == 0)
            cfg_wr(8'h01, 8'($urandom_range(0, 3)));
         txn(4'($urandom_range(0, 15)), 20'($urandom()), 1'($urandom()), 8'($urandom()));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule